// File: doc/BRIEF.md
# TDM Backplane Byte Interleaver

This block merges several framed PCM streams, each carrying one octet per timeslot, onto a single serial backplane line. It works in two line rates. The narrow line carries two streams in 64 octet slots per frame, 512 bit periods. The wide line carries four streams in 128 slots per frame, 1024 bit periods. Octets from the streams are taken in turn, one per stream per turn, in stream order 0, 1, 2, 3. When the streams are 24-slot T1 frames, the block puts a group of idle slots ahead of every three data groups. This pads each stream out to the 32-slot frame that the backplane expects.

An external frame pulse sets the frame phase. The block needs no host. A small state machine stays in HUNT and holds the line at mark until it sees the first pulse (ACQUIRE). It then stays in LOCK. While in LOCK, a bit counter runs freely and rolls over at the end of each frame (ROLL). A pulse that comes exactly at the rollover point restarts the frame quietly (REFRAME). A pulse at any other point forces the frame to restart (RESYNC) and sets an alignment error flag that stays set. Each stream gives its next octet on a parallel port. The block raises that stream's request strobe in the cycle in which the octet is taken, and it reports the timeslot number of that octet at the same time.

Top module: `tdm_byte_interleaver`

## Requirements
- R1: While reset is asserted, and after reset until the first frame pulse, `line_o` is 1, `req_o` is 0 and `align_err_o` is 0.
- R2: When `frame_pulse_i` is high at a rising edge, the cycle after that edge drives bit 7 of slot 0. Octets go out MSB first, one bit per clock, and slot k fills bit periods 8k to 8k+7 of the frame.
- R3: With mode code 1 (two E1, 512-bit frame), slot k carries stream k mod 2, timeslot k/2. Every slot carries data.
- R4: With mode code 2 (four E1, 1024-bit frame), slot k carries stream k mod 4, timeslot k/4.
- R5: With mode code 0 (two T1, 512-bit frame), take group g = k/2. If g mod 4 = 0, slot k is idle. Otherwise it carries stream k mod 2, timeslot 3*(g/4) + (g mod 4) - 1.
- R6: With mode code 3 (four T1, 1024-bit frame), take group g = k/4. If g mod 4 = 0, slot k is idle. Otherwise it carries stream k mod 4, timeslot 3*(g/4) + (g mod 4) - 1.
- R7: An idle slot carries `idle_octet_i` and raises no request.
- R8: For each data slot, `req_o[s]` (bit s for stream s) is high for exactly the one cycle that precedes the slot's first bit. `byte_i[8s+7:8s]` is taken at the end of that cycle, and in the same cycle `ts_o` shows the timeslot of that octet. At most one request bit is high at a time.
- R9: `mode_i` is read only at a rising edge with the frame pulse high. A change in the middle of a frame does not alter the frame in progress.
- R10: With no further pulse, the frame repeats every 512 bit periods (codes 0 and 1) or every 1024 bit periods (codes 2 and 3).
- R11: A pulse that does not fall where the next frame would start anyway still restarts the frame at slot 0, and it sets `align_err_o`. The flag stays set until reset. A pulse at the rollover point, or the first pulse after reset, does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_pulse_i | input | 1 | Frame start marker |
| mode_i | input | 2 | Mode code: 0 two T1, 1 two E1, 2 four E1, 3 four T1 |
| idle_octet_i | input | 8 | Octet sent in idle slots |
| byte_i | input | 32 | Next octet of each stream, stream s in bits 8s+7..8s |
| req_o | output | 4 | Per-stream octet take strobe |
| ts_o | output | 5 | Timeslot number of the octet being taken |
| line_o | output | 1 | Serial backplane line |
| align_err_o | output | 1 | Alignment error flag, cleared only by reset |

## Verification
Each mode is tried with new random octets on every stream in every cycle, so a wrong lane, a wrong timeslot order or a byte taken in the wrong cycle all show up as a line-bit mismatch. The two T1 modes are also run with an idle octet other than all-ones, which separates idle filling from plain line marking. Mode changes are applied in the middle of a frame and also at the pulse, which shows whether the mode is read only at the frame boundary. A long stretch with no pulse is followed by an off-phase pulse and then in-phase pulses, which covers rollover, resync and the flag staying set.

// File: rtl/tdm_pkg.sv
`timescale 1ns/1ps
package tdm_pkg;

    typedef enum logic [1:0] {
        MODE_2T1 = 2'd0,
        MODE_2E1 = 2'd1,
        MODE_4E1 = 2'd2,
        MODE_4T1 = 2'd3
    } bp_mode_e;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } sync_state_e;

    function automatic logic mode_is_t1(bp_mode_e m);
        return (m == MODE_2T1) || (m == MODE_4T1);
    endfunction

    function automatic logic mode_is_wide(bp_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/tdm_frame_ctrl.sv
`timescale 1ns/1ps
module tdm_frame_ctrl
    import tdm_pkg::*;
#(
    parameter int BASE_SLOTS = 64,
    parameter int OCTET_W    = 8,
    localparam int BIT_W     = $clog2(OCTET_W),
    localparam int SLOT_W    = $clog2(2 * BASE_SLOTS),
    localparam int POS_W     = SLOT_W + BIT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fp_i,
    input  bp_mode_e         mode_i,
    output logic [POS_W-1:0] pos_o,
    output logic [POS_W-1:0] nxt_pos_o,
    output bp_mode_e         nxt_mode_o,
    output logic             load_o,
    output logic             align_err_o
);

    localparam int NARROW_LAST = BASE_SLOTS * OCTET_W - 1;
    localparam int WIDE_LAST   = 2 * BASE_SLOTS * OCTET_W - 1;

    sync_state_e      state_q, state_d;
    logic [POS_W-1:0] pos_q, roll_pos, frame_last;
    bp_mode_e         mode_q;
    logic             err_q, misalign;

    // state register and frame registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            pos_q   <= '0;
            mode_q  <= MODE_2T1;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pos_q   <= nxt_pos_o;
            mode_q  <= nxt_mode_o;
            err_q   <= err_q | misalign;
        end
    end

    // next state: ACQUIRE leaves HUNT; ROLL, REFRAME, RESYNC all stay in LOCK
    always_comb begin
        unique case (state_q)
            ST_HUNT: state_d = fp_i ? ST_LOCK : ST_HUNT;
            ST_LOCK: state_d = ST_LOCK;
            default: state_d = ST_HUNT;
        endcase
    end

    // outputs
    always_comb begin
        frame_last  = mode_is_wide(mode_q) ? POS_W'(WIDE_LAST) : POS_W'(NARROW_LAST);
        roll_pos    = (pos_q == frame_last) ? '0 : pos_q + 1'b1;
        nxt_pos_o   = fp_i ? '0 : roll_pos;
        nxt_mode_o  = fp_i ? mode_i : mode_q;
        load_o      = (state_d == ST_LOCK) && (nxt_pos_o[BIT_W-1:0] == '0);
        misalign    = fp_i && (state_q == ST_LOCK) && (roll_pos != '0);
        pos_o       = pos_q;
        align_err_o = err_q;
    end

    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        align_err_o |=> align_err_o);

    a_r10_roll_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && !fp_i && pos_q == frame_last) |=> (pos_q == '0));

    a_r9_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        !fp_i |=> $stable(mode_q));

endmodule

// File: rtl/tdm_slot_map.sv
`timescale 1ns/1ps
module tdm_slot_map
    import tdm_pkg::*;
#(
    parameter int BASE_SLOTS = 64,
    parameter int LANES      = 4,
    localparam int SLOT_W    = $clog2(2 * BASE_SLOTS),
    localparam int LW        = $clog2(LANES),
    localparam int GRP_W     = SLOT_W - LW,
    localparam int TS_W      = GRP_W
) (
    input  bp_mode_e          mode_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic              data_v_o,
    output logic [LW-1:0]     lane_o,
    output logic [TS_W-1:0]   ts_o
);

    logic [GRP_W-1:0] grp;

    always_comb begin
        if (mode_is_wide(mode_i)) begin
            lane_o = slot_i[LW-1:0];
            grp    = slot_i[SLOT_W-1:LW];
        end else begin
            lane_o = {1'b0, slot_i[LW-2:0]};
            grp    = slot_i[SLOT_W-2:LW-1];
        end

        if (mode_is_t1(mode_i)) begin
            // one idle group ahead of every three data groups
            data_v_o = (grp[1:0] != 2'd0);
            ts_o     = TS_W'(grp[GRP_W-1:2]) * TS_W'(3) + TS_W'(grp[1:0]) - TS_W'(1);
        end else begin
            data_v_o = 1'b1;
            ts_o     = TS_W'(grp);
        end
    end

endmodule

// File: rtl/tdm_shifter.sv
`timescale 1ns/1ps
module tdm_shifter #(
    parameter int OCTET_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [OCTET_W-1:0] octet_i,
    output logic               line_o
);

    logic [OCTET_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '1;
        end else if (load_i) begin
            shreg <= octet_i;
        end else begin
            shreg <= {shreg[OCTET_W-2:0], 1'b1};
        end
    end

    assign line_o = shreg[OCTET_W-1];

endmodule

// File: rtl/tdm_byte_interleaver.sv
`timescale 1ns/1ps
module tdm_byte_interleaver
    import tdm_pkg::*;
#(
    parameter int BASE_SLOTS = 64,
    parameter int LANES      = 4,
    parameter int OCTET_W    = 8,
    localparam int BIT_W     = $clog2(OCTET_W),
    localparam int SLOT_W    = $clog2(2 * BASE_SLOTS),
    localparam int POS_W     = SLOT_W + BIT_W,
    localparam int LW        = $clog2(LANES),
    localparam int TS_W      = SLOT_W - LW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_pulse_i,
    input  logic [1:0]               mode_i,
    input  logic [OCTET_W-1:0]       idle_octet_i,
    input  logic [LANES*OCTET_W-1:0] byte_i,
    output logic [LANES-1:0]         req_o,
    output logic [TS_W-1:0]          ts_o,
    output logic                     line_o,
    output logic                     align_err_o
);

    logic [POS_W-1:0]   pos_q, nxt_pos;
    bp_mode_e           nxt_mode;
    logic               load, data_v;
    logic [LW-1:0]      lane;
    logic [TS_W-1:0]    ts;
    logic [OCTET_W-1:0] octet;

    tdm_frame_ctrl #(.BASE_SLOTS(BASE_SLOTS), .OCTET_W(OCTET_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fp_i        (frame_pulse_i),
        .mode_i      (bp_mode_e'(mode_i)),
        .pos_o       (pos_q),
        .nxt_pos_o   (nxt_pos),
        .nxt_mode_o  (nxt_mode),
        .load_o      (load),
        .align_err_o (align_err_o)
    );

    tdm_slot_map #(.BASE_SLOTS(BASE_SLOTS), .LANES(LANES)) u_map (
        .mode_i   (nxt_mode),
        .slot_i   (nxt_pos[POS_W-1:BIT_W]),
        .data_v_o (data_v),
        .lane_o   (lane),
        .ts_o     (ts)
    );

    always_comb begin
        octet = data_v ? byte_i[int'(lane)*OCTET_W +: OCTET_W] : idle_octet_i;
    end

    for (genvar s = 0; s < LANES; s++) begin : g_req
        assign req_o[s] = load && data_v && (lane == LW'(s));
    end

    assign ts_o = ts;

    tdm_shifter #(.OCTET_W(OCTET_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .octet_i (octet),
        .line_o  (line_o)
    );

    a_r8_one_req: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_o));

    a_r8_req_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_o) |=> (pos_q[BIT_W-1:0] == '0));

    a_r2_pulse_restart: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse_i |=> (pos_q == '0));

endmodule

// File: tb/test_tdm_byte_interleaver.sv
`timescale 1ns/1ps
module test_tdm_byte_interleaver;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_pulse_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic [7:0]  idle_octet_i = 8'hFF;
    logic [31:0] byte_i = '0;
    logic [3:0]  req_o;
    logic [4:0]  ts_o;
    logic        line_o;
    logic        align_err_o;

    int    vectors = 0;
    int    miscompares = 0;
    string tag = "R1";
    bit    done = 0;

    always #10 clk = ~clk;

    tdm_byte_interleaver i_tdm_byte_interleaver (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_pulse_i (frame_pulse_i),
        .mode_i        (mode_i),
        .idle_octet_i  (idle_octet_i),
        .byte_i        (byte_i),
        .req_o         (req_o),
        .ts_o          (ts_o),
        .line_o        (line_o),
        .align_err_o   (align_err_o)
    );

    // ---------------- behavioural reference model ----------------
    int       m_pos, m_mode;
    bit       m_lock, m_err;
    bit [7:0] m_oct;
    logic     m_ser;

    function automatic int flen(int md);
        return (md >= 2) ? 1024 : 512;
    endfunction

    function automatic void owner(input int md, input int slot,
                                  output bit v, output int s, output int ts);
        int n, g;
        bit t1;
        n  = (md >= 2) ? 4 : 2;
        t1 = (md == 0) || (md == 3);
        s  = slot % n;
        g  = slot / n;
        if (t1) begin
            v  = (g % 4) != 0;
            ts = 3 * (g / 4) + (g % 4) - 1;
        end else begin
            v  = 1;
            ts = g;
        end
    endfunction

    always @(posedge clk) begin
        bit v;
        int s, ts, len;
        if (!rst_n) begin
            m_pos = 0; m_mode = 0; m_lock = 0; m_err = 0; m_oct = 8'hFF; m_ser = 1'b1;
        end else begin
            len = flen(m_mode);
            if (frame_pulse_i) begin
                if (m_lock && ((m_pos + 1) % len) != 0) m_err = 1;
                m_lock = 1;
                m_mode = int'(mode_i);
                m_pos  = 0;
            end else begin
                m_pos = (m_pos + 1) % len;
            end
            if (m_lock && (m_pos % 8) == 0) begin
                owner(m_mode, m_pos / 8, v, s, ts);
                m_oct = v ? byte_i[s*8 +: 8] : idle_octet_i;
            end
            m_ser = m_lock ? m_oct[7 - (m_pos % 8)] : 1'b1;
        end
    end

    // ---------------- checking ----------------
    task automatic compare();
        bit       v, wl;
        int       s, ts, nm, np;
        bit [3:0] er;
        int       ets;
        er  = '0;
        ets = 0;
        wl  = m_lock || frame_pulse_i;
        nm  = frame_pulse_i ? int'(mode_i) : m_mode;
        np  = frame_pulse_i ? 0 : (m_pos + 1) % flen(m_mode);
        if (wl && (np % 8) == 0) begin
            owner(nm, np / 8, v, s, ts);
            if (v) begin
                er[s] = 1'b1;
                ets   = ts;
            end
        end
        vectors++;
        if (line_o !== m_ser) begin
            miscompares++;
            $display("FAIL %s line_o got %b expected %b (pos %0d)", tag, line_o, m_ser, m_pos);
        end
        if (req_o !== er) begin
            miscompares++;
            $display("FAIL R8 req_o got %b expected %b (pos %0d)", req_o, er, m_pos);
        end else if (er != 0 && int'(ts_o) != ets) begin
            miscompares++;
            $display("FAIL R8 ts_o got %0d expected %0d", ts_o, ets);
        end
        if (align_err_o !== m_err) begin
            miscompares++;
            $display("FAIL R11 align_err_o got %b expected %b", align_err_o, m_err);
        end
    endtask

    task automatic tick(input bit fp);
        @(negedge clk);
        frame_pulse_i = fp;
        byte_i        = $urandom;
        #1;
        compare();
    endtask

    task automatic run_frame(input int cycles);
        tick(1'b1);
        for (int i = 1; i < cycles; i++) tick(1'b0);
    endtask

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        vectors++;
        if (line_o !== 1'b1 || req_o !== 4'b0 || align_err_o !== 1'b0) begin
            miscompares++;
            $display("FAIL R1 reset got line %b req %b err %b expected 1 0000 0",
                     line_o, req_o, align_err_o);
        end
        rst_n = 1'b1;
        tag = "R1";
        for (int i = 0; i < 30; i++) tick(1'b0);

        // R2 then R3: two E1 on the narrow line
        mode_i = 2'd1;
        tag = "R2";
        tick(1'b1);
        for (int i = 0; i < 15; i++) tick(1'b0);
        tag = "R3";
        for (int i = 0; i < 496; i++) tick(1'b0);

        // R9: mode change mid-frame ignored until the pulse
        tag = "R9";
        tick(1'b1);
        for (int i = 1; i < 100; i++) tick(1'b0);
        mode_i = 2'd2;
        for (int i = 100; i < 512; i++) tick(1'b0);

        // R4: four E1
        tag = "R4";
        run_frame(1024);

        // R5: two T1, default idle
        mode_i = 2'd0;
        tag = "R5";
        run_frame(512);

        // R7: idle octet distinct from mark
        idle_octet_i = 8'h5A;
        tag = "R7";
        run_frame(512);

        // R6: four T1
        mode_i = 2'd3;
        tag = "R6";
        run_frame(1024);

        // R10: free run without pulses
        tag = "R10";
        for (int i = 0; i < 2000; i++) tick(1'b0);

        // R11: off-phase pulse then in-phase pulses
        mode_i = 2'd2;
        idle_octet_i = 8'hFF;
        tag = "R11";
        run_frame(1024);
        run_frame(1024);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule